// File: doc/BRIEF.md
# Oversampled Serial Receive Bit Recovery

This block is the front end of an asynchronous serial receiver. The line is first brought into the local clock domain by a short synchronizer. After that it is read only on cycles where a sample enable is high. The enable comes from an external rate generator and pulses sixteen times per bit period. Each bit period is split into sixteen sample phases, numbered RT1 to RT16. The block hunts for a start bit and checks it with three early samples. It then decides each data bit by a three-sample majority vote.

A sample counter is restarted at every accepted start bit. It is restarted again at every falling line edge that follows a bit voted 1. This lets frames sent a little fast or a little slow still be read correctly. Each decided bit is reported with a one-cycle strobe. At the stop-bit decision, the assembled byte is presented together with a noise indication and a framing-error pulse.

Top module: `uart_rx_recover`

## Requirements
- R1: Hunting looks at the synchronized line on enabled samples only. A sample of 0 whose three previous samples were all 1 is taken as phase RT1 of a candidate start bit. A 0 that follows fewer than three 1s never starts a frame.
- R2: The candidate is judged on the samples at RT3, RT5 and RT7. If two or more of them are 1, the candidate is dropped and hunting resumes without any pulse. Otherwise `start_pulse` is high for one cycle right after the RT7 sample.
- R3: A start bit accepted with exactly one of its three judging samples at 1 sets the frame's noise indication. A start bit with all three samples at 0 does not.
- R4: Each data bit and the stop bit take the majority of the samples at RT8, RT9 and RT10. `bit_valid` pulses with the voted value on `bit_value`. Data bits arrive least significant first into `byte_data` bit 0 to bit 7.
- R5: A data or stop bit whose three vote samples are not all equal sets the frame's noise indication. The indication builds up over the frame and appears on `noise` with the byte.
- R6: After a bit voted 1, the next falling line edge restarts the phase count at RT1. If the edge is seen at RT12 to RT16, the count moves on to the next bit. If it is seen at RT2 to RT7, the count stays in the current bit. With this, alternating data is read correctly at 15 and at 18 sample enables per bit.
- R7: The stop-bit vote raises `byte_valid` for one cycle. `frame_err` pulses in the same cycle exactly when that vote is 0.
- R8: After the stop-bit decision the block hunts again, so back-to-back frames are each received.
- R9: While reset is held, and right after it, all strobes, `byte_data` and `noise` are 0.
- R10: Cycles with `tick` low do not advance the sample count. A frame sent with two or three clocks per sample is received the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| start_pulse | output | 1 | One-cycle pulse on an accepted start bit |
| bit_valid | output | 1 | One-cycle pulse on each voted data or stop bit |
| bit_value | output | 1 | Value of the most recently voted bit |
| byte_valid | output | 1 | One-cycle pulse at the stop-bit decision |
| byte_data | output | 8 | Assembled byte, held until the next frame |
| noise | output | 1 | Noise seen in the frame, presented with the byte |
| frame_err | output | 1 | Stop bit voted 0, pulses with byte_valid |

## Verification
The hardest states to reach are the phase corrections. Each one needs a falling edge at a chosen offset from the local bit boundary, after a bit voted 1. The bench builds the line one sample enable at a time. Stretching or shrinking every bit to 18 or 15 samples makes the edges arrive late or early, and alternating data patterns give many such edges per frame. The same per-sample construction places single-sample glitches exactly on RT3, RT5, RT7 or a data bit's RT9, which reaches each verification noise pattern and each reject pattern on purpose.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_DATA   = 2'd2
  } rx_state_e;

  localparam int PH_W = 4;
  // zero-based sample phases (RTn is n-1)
  localparam logic [PH_W-1:0] PH_V1   = 4'd2;
  localparam logic [PH_W-1:0] PH_V2   = 4'd4;
  localparam logic [PH_W-1:0] PH_V3   = 4'd6;
  localparam logic [PH_W-1:0] PH_D1   = 4'd7;
  localparam logic [PH_W-1:0] PH_D2   = 4'd8;
  localparam logic [PH_W-1:0] PH_D3   = 4'd9;
  localparam logic [PH_W-1:0] PH_LATE = 4'd6;
  localparam logic [PH_W-1:0] PH_EARLY = 4'd11;
  localparam logic [PH_W-1:0] PH_LAST = 4'd15;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b1;
          else        stg_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 1'b1;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
  input  logic [2:0] smp,
  output logic       maj,
  output logic       split
);
  always_comb begin
    maj   = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
    split = (smp != 3'b000) && (smp != 3'b111);
  end
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 samp,
  output logic                 start_pulse,
  output logic                 bit_valid,
  output logic                 bit_value,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 noise,
  output logic                 frame_err
);
  localparam int IDX_W = $clog2(DATA_BITS + 2);
  localparam logic [IDX_W-1:0] IDX_LAST_DATA = IDX_W'(DATA_BITS);

  rx_state_e             state_q, state_d;
  logic [PH_W-1:0]       ph_q, ph_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [2:0]            hist_q, hist_d;
  logic                  v1_q, v1_d, v2_q, v2_d;
  logic                  d1_q, d1_d, d2_q, d2_d;
  logic [DATA_BITS-1:0]  sh_q, sh_d;
  logic                  nz_q, nz_d;
  logic                  arm_q, arm_d;
  logic                  start_q, start_d;
  logic                  bv_q, bv_d;
  logic                  bval_q, bval_d;
  logic                  byv_q, byv_d;
  logic [DATA_BITS-1:0]  byte_q, byte_d;
  logic                  nzo_q, nzo_d;
  logic                  fe_q, fe_d;

  logic ver_maj, ver_split, dat_maj, dat_split;
  logic [PH_W-1:0] cur_raw, cur;
  logic fall, early, late;

  rx_vote3 u_vote_start (.smp({v1_q, v2_q, samp}), .maj(ver_maj), .split(ver_split));
  rx_vote3 u_vote_data  (.smp({d1_q, d2_q, samp}), .maj(dat_maj), .split(dat_split));

  always_comb begin
    cur_raw = ph_q + 1'b1;
    fall    = hist_q[0] & ~samp;
    early   = arm_q & fall & (cur_raw >= PH_EARLY);
    late    = arm_q & fall & (cur_raw <= PH_LATE);
    cur     = (early | late) ? '0 : cur_raw;
  end

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    idx_d   = idx_q;
    hist_d  = hist_q;
    v1_d    = v1_q;
    v2_d    = v2_q;
    d1_d    = d1_q;
    d2_d    = d2_q;
    sh_d    = sh_q;
    nz_d    = nz_q;
    arm_d   = arm_q;
    start_d = 1'b0;
    bv_d    = 1'b0;
    bval_d  = bval_q;
    byv_d   = 1'b0;
    byte_d  = byte_q;
    nzo_d   = nzo_q;
    fe_d    = 1'b0;
    if (tick) begin
      hist_d = {hist_q[1:0], samp};
      unique case (state_q)
        ST_HUNT: begin
          if (!samp && (hist_q == 3'b111)) begin
            state_d = ST_VERIFY;
            ph_d    = '0;
            nz_d    = 1'b0;
          end
        end
        ST_VERIFY: begin
          ph_d = cur_raw;
          if (cur_raw == PH_V1) v1_d = samp;
          if (cur_raw == PH_V2) v2_d = samp;
          if (cur_raw == PH_V3) begin
            if (ver_maj) begin
              state_d = ST_HUNT;
            end else begin
              start_d = 1'b1;
              nz_d    = ver_split;
              state_d = ST_DATA;
              idx_d   = '0;
              arm_d   = 1'b0;
            end
          end
        end
        ST_DATA: begin
          ph_d = cur;
          if (early | late) arm_d = 1'b0;
          if ((ph_q == PH_LAST) || early) idx_d = idx_q + 1'b1;
          if (cur == PH_D1) d1_d = samp;
          if (cur == PH_D2) d2_d = samp;
          if ((cur == PH_D3) && (idx_q != '0)) begin
            bv_d   = 1'b1;
            bval_d = dat_maj;
            if (idx_q <= IDX_LAST_DATA) begin
              sh_d  = {dat_maj, sh_q[DATA_BITS-1:1]};
              nz_d  = nz_q | dat_split;
              arm_d = dat_maj;
            end else begin
              byv_d   = 1'b1;
              byte_d  = sh_q;
              nzo_d   = nz_q | dat_split;
              fe_d    = ~dat_maj;
              state_d = ST_HUNT;
            end
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      ph_q    <= '0;
      idx_q   <= '0;
      hist_q  <= 3'b111;
      v1_q    <= 1'b0;
      v2_q    <= 1'b0;
      d1_q    <= 1'b0;
      d2_q    <= 1'b0;
      sh_q    <= '0;
      nz_q    <= 1'b0;
      arm_q   <= 1'b0;
      start_q <= 1'b0;
      bv_q    <= 1'b0;
      bval_q  <= 1'b0;
      byv_q   <= 1'b0;
      byte_q  <= '0;
      nzo_q   <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      idx_q   <= idx_d;
      hist_q  <= hist_d;
      v1_q    <= v1_d;
      v2_q    <= v2_d;
      d1_q    <= d1_d;
      d2_q    <= d2_d;
      sh_q    <= sh_d;
      nz_q    <= nz_d;
      arm_q   <= arm_d;
      start_q <= start_d;
      bv_q    <= bv_d;
      bval_q  <= bval_d;
      byv_q   <= byv_d;
      byte_q  <= byte_d;
      nzo_q   <= nzo_d;
      fe_q    <= fe_d;
    end
  end

  assign start_pulse = start_q;
  assign bit_valid   = bv_q;
  assign bit_value   = bval_q;
  assign byte_valid  = byv_q;
  assign byte_data   = byte_q;
  assign noise       = nzo_q;
  assign frame_err   = fe_q;
endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover #(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 rxd,
  output logic                 start_pulse,
  output logic                 bit_valid,
  output logic                 bit_value,
  output logic                 byte_valid,
  output logic [DATA_BITS-1:0] byte_data,
  output logic                 noise,
  output logic                 frame_err
);
  logic line_s;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .samp       (line_s),
    .start_pulse(start_pulse),
    .bit_valid  (bit_valid),
    .bit_value  (bit_value),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .noise      (noise),
    .frame_err  (frame_err)
  );
endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic start_pulse,
  input logic bit_valid,
  input logic byte_valid,
  input logic frame_err
);
  p_byte_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  p_ferr_with_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> byte_valid);

  p_strobe_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse || bit_valid || byte_valid) |-> $past(tick));

  p_start_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !bit_valid);

  p_byte_on_vote_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> bit_valid);

  p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
endmodule

bind uart_rx_recover uart_rx_recover_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .start_pulse(start_pulse),
  .bit_valid  (bit_valid),
  .byte_valid (byte_valid),
  .frame_err  (frame_err)
);

// File: tb/uart_rx_recover_tb_top.sv
`timescale 1ns/1ps
module uart_rx_recover_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic rxd = 1'b1;
  logic start_pulse, bit_valid, bit_value, byte_valid, noise, frame_err;
  logic [7:0] byte_data;

  int checks = 0;
  int errors = 0;
  int st_cnt = 0, bv_cnt = 0, by_cnt = 0;
  logic [7:0] got_byte;
  logic got_noise, got_ferr;
  logic [8:0] bit_sh;

  always #2 clk = ~clk;

  uart_rx_recover dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .start_pulse(start_pulse), .bit_valid(bit_valid), .bit_value(bit_value),
    .byte_valid(byte_valid), .byte_data(byte_data), .noise(noise),
    .frame_err(frame_err)
  );

  typedef struct packed {
    logic [7:0] b;
    logic [4:0] tpb;
    logic       stp;
    logic [1:0] gap;
    logic       exp_ferr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'h55, 5'd16, 1'b1, 2'd2, 1'b0},
    '{8'hA3, 5'd16, 1'b1, 2'd3, 1'b0},
    '{8'h00, 5'd16, 1'b1, 2'd2, 1'b0},
    '{8'hFF, 5'd16, 1'b1, 2'd2, 1'b0},
    '{8'h55, 5'd18, 1'b1, 2'd2, 1'b0},
    '{8'hAA, 5'd18, 1'b1, 2'd3, 1'b0},
    '{8'h55, 5'd15, 1'b1, 2'd2, 1'b0},
    '{8'hAA, 5'd15, 1'b1, 2'd2, 1'b0},
    '{8'h3C, 5'd16, 1'b0, 2'd2, 1'b1}
  };

  always @(negedge clk) begin
    if (start_pulse) st_cnt++;
    if (bit_valid) begin
      bv_cnt++;
      bit_sh = {bit_value, bit_sh[8:1]};
    end
    if (byte_valid) begin
      by_cnt++;
      got_byte  = byte_data;
      got_noise = noise;
      got_ferr  = frame_err;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int gap);
    rxd = v;
    repeat (gap) @(posedge clk);
    #1 tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 2);
  endtask

  task automatic send_frame(input logic [7:0] b, input int tpb, input logic stp,
                            input int gap, input int g1, input int g2, input int tail);
    for (int i = 0; i < tpb * 10; i++) begin
      int bn;
      logic v;
      bn = i / tpb;
      if (bn == 0)      v = 1'b0;
      else if (bn <= 8) v = b[bn-1];
      else              v = stp;
      if (i == g1 || i == g2) v = ~v;
      step(v, gap);
    end
    idle(tail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, b0, y0;
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(!start_pulse && !bit_valid && !byte_valid && !frame_err && byte_data == 8'h00 && !noise,
          "R9 outputs in reset", {start_pulse, bit_valid, byte_valid, frame_err, noise}, 0);
    rst_n = 1'b1;
    idle(6);
    check(st_cnt == 0 && by_cnt == 0, "R9 quiet after reset", st_cnt + by_cnt, 0);

    // table walk: R4 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      s0 = st_cnt; b0 = bv_cnt; y0 = by_cnt;
      send_frame(VECS[k].b, VECS[k].tpb, VECS[k].stp, VECS[k].gap, -1, -1, 8);
      check(by_cnt == y0 + 1 && got_byte == VECS[k].b, "R4/R6/R10 byte", got_byte, VECS[k].b);
      check(got_ferr == VECS[k].exp_ferr, "R7 frame_err", got_ferr, VECS[k].exp_ferr);
      check(!got_noise, "R5 clean frame noise", got_noise, 0);
      check(bv_cnt == b0 + 9 && st_cnt == s0 + 1, "R8 strobe counts", bv_cnt - b0, 9);
      check(bit_sh == {VECS[k].stp, VECS[k].b}, "R4 bit strobes", bit_sh, {VECS[k].stp, VECS[k].b});
    end

    // R3: accepted with noise, sample pattern 100 (RT3 high)
    send_frame(8'h96, 16, 1'b1, 2, 2, -1, 8);
    check(got_byte == 8'h96 && got_noise, "R3 pattern 100 noise", {got_noise, got_byte}, 9'h196);
    // R3: pattern 001 (RT7 high)
    send_frame(8'h69, 16, 1'b1, 2, 6, -1, 8);
    check(got_byte == 8'h69 && got_noise, "R3 pattern 001 noise", {got_noise, got_byte}, 9'h169);
    // R3: pattern 010 (RT5 high)
    send_frame(8'h0F, 16, 1'b1, 3, 4, -1, 8);
    check(got_byte == 8'h0F && got_noise, "R3 pattern 010 noise", {got_noise, got_byte}, 9'h10F);

    // R2: reject pattern 110 (RT3 and RT5 high)
    s0 = st_cnt; y0 = by_cnt;
    for (int i = 0; i < 7; i++) step((i == 2 || i == 4), 2);
    idle(30);
    check(st_cnt == s0 && by_cnt == y0, "R2 reject 110", st_cnt - s0, 0);
    // R2: reject 111 (one-sample low pulse)
    step(1'b0, 2);
    idle(30);
    check(st_cnt == s0 && by_cnt == y0, "R2 reject 111", st_cnt - s0, 0);

    // R5: data-bit noise at bit 0 RT9
    send_frame(8'hC5, 16, 1'b1, 2, 24, -1, 8);
    check(got_byte == 8'hC5 && got_noise, "R5 data split noise", {got_noise, got_byte}, 9'h1C5);
    // R5 noise cleared on next clean frame
    send_frame(8'h5A, 16, 1'b1, 2, -1, -1, 8);
    check(!got_noise && got_byte == 8'h5A, "R5 noise cleared", {got_noise, got_byte}, 9'h05A);

    // R1: low after fewer than three ones never starts
    send_frame(8'h00, 16, 1'b0, 2, -1, -1, 0);
    check(got_ferr, "R7 stop low", got_ferr, 1);
    s0 = st_cnt;
    for (int r = 0; r < 10; r++) begin
      step(1'b1, 2); step(1'b1, 2); step(1'b0, 2);
    end
    for (int i = 0; i < 20; i++) step(1'b0, 2);
    check(st_cnt == s0, "R1 no start without three ones", st_cnt - s0, 0);

    // R8: recovery and back-to-back frames
    idle(4);
    y0 = by_cnt;
    send_frame(8'h81, 16, 1'b1, 2, -1, -1, 3);
    send_frame(8'h7E, 16, 1'b1, 2, -1, -1, 8);
    check(by_cnt == y0 + 2 && got_byte == 8'h7E, "R8 back-to-back", by_cnt - y0, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule